// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block decides, for a bank of device endpoints, how each incoming bus token is answered. Every endpoint slot holds a buffer segment, an armed length, a configuration (endpoint number, direction, isochronous mode, data toggle, setup stall override) and a stall control. When the token decoder presents a token (kind, endpoint number, received byte count and the data PID of an OUT packet), the block routes it to a slot, picks the handshake, updates the slot's readiness, toggle and stored length, and reports a 3-bit outcome code with an overrun flag.

The outputs drive the packet engine: the handshake to send, the DATA0/DATA1 choice and byte count for IN data, and the buffer offset within packet RAM. Bit-level signalling, CRC and the RAM datapath live elsewhere. Software-side writes arrive on a simple register port that selects a slot and a register.

Top module: `usb_ep_handshake`

## Requirements
- R1: A segment write takes reg_wdata_i[8:3]; the slot's buffer offset is that field followed by three zero bits, both on readback (reg_sel 0) and on resp_addr_o for IN and OUT tokens, so buffers start on 8-byte boundaries.
- R2: Writing the length register (reg_sel 1) stores reg_wdata_i[8:0] and arms the slot; an IN token to an armed non-isochronous slot answers resp_hs_o=01 (data sent) with resp_len_o equal to the armed length, then disarms the slot.
- R3: Writing 1 to bit 0 of the control register (reg_sel 3) disarms the slot; that bit always reads back 0, while bit 1 holds the stall control.
- R4: A token matches a slot whose number (config bits 11:8) equals the token's number and whose direction (config bits 1:0: 00 off, 01 OUT, 10 IN, 11 undefined) fits: IN tokens need 10, OUT tokens need 01, SETUP tokens accept 01 or 10. Off and undefined slots never match; the lowest matching slot wins; an unmatched token gets resp_hs_o=00 and no status.
- R5: resp_data1_o for IN data equals the slot's toggle (config bit 3); the toggle inverts after each non-isochronous IN data answer and is unchanged by NAK or STALL.
- R6: A token to a matched slot that is not armed and not stalled gets NAK (resp_hs_o=10); for IN the status code is 001, for OUT no status is reported.
- R7: A stalled slot answers IN and OUT tokens with STALL (resp_hs_o=11), reports no status and keeps its armed state; a SETUP token to a stalled slot gets STALL unless the setup stall override (config bit 4) is set.
- R8: An OUT token to an armed non-isochronous slot gets ACK with status 010 when the packet was DATA0 and 110 when DATA1; the length register then reads back the received count and the slot is disarmed.
- R9: overrun_o is raised with the status when OUT data exceeds the armed length (the stored count is then the armed length) or when a SETUP packet exceeds 8 bytes.
- R10: An isochronous slot never sends a handshake (resp_hs_o=00); an armed one reports status 111 and is disarmed, an unarmed one reports nothing.
- R11: A SETUP token that is not stalled gets ACK with status 011 and resp_addr_o taken from the setup segment register (reg_sel 4), whether or not the slot is armed.
- R12: After reset all registers read 0, and no response or status is reported until a token arrives; token kinds are 00 OUT, 01 IN, 10 SETUP, 11 ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_ep_i | input | 3 | Slot written |
| reg_sel_i | input | 3 | Register written: 0 segment, 1 length, 2 config, 3 control, 4 setup segment |
| reg_wdata_i | input | 12 | Write data |
| reg_rd_ep_i | input | 3 | Slot read |
| reg_rd_sel_i | input | 3 | Register read, same codes as reg_sel_i |
| reg_rdata_o | output | 12 | Read data, combinational |
| tok_valid_i | input | 1 | Token strobe |
| tok_pid_i | input | 2 | Token kind |
| tok_ep_i | input | 4 | Token endpoint number |
| tok_len_i | input | 10 | Received byte count |
| tok_data1_i | input | 1 | OUT packet was DATA1 |
| resp_valid_o | output | 1 | Response valid, one cycle after the token |
| resp_hs_o | output | 2 | 00 none, 01 ACK or IN data, 10 NAK, 11 STALL |
| resp_data1_o | output | 1 | IN data uses DATA1 |
| resp_len_o | output | 9 | IN data byte count |
| resp_addr_o | output | 9 | Buffer offset in packet RAM |
| sts_valid_o | output | 1 | Outcome status valid |
| sts_code_o | output | 3 | Outcome code |
| sts_slot_o | output | 3 | Slot that handled the token |
| overrun_o | output | 1 | Received data exceeded its limit |

## Verification
The bench targets the toggle sequence across ACK, NAK and STALL, where a design that flipped on NAK or forgot to flip would send the wrong DATA PID on the next transfer. It checks that a stall leaves the armed state intact and that a cleared stall resumes with the same length, which catches designs that disarm on STALL. Overrun is driven one byte past the limit for both OUT and SETUP, catching an off-by-one comparison, and routing is probed with disabled, undefined and duplicate-number slots, where a wrong match order sends the status to the wrong slot. Isochronous slots are hit twice to show the second token produces neither handshake nor status.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int unsigned LEN_W  = 9;
  localparam int unsigned SEG_W  = 6;
  localparam int unsigned ADDR_W = SEG_W + 3;
  localparam int unsigned NUM_W  = 4;
  localparam int unsigned REG_W  = 12;
  localparam int unsigned SETUP_MAX = 8;

  localparam logic [2:0] SEL_SEG   = 3'd0;
  localparam logic [2:0] SEL_LEN   = 3'd1;
  localparam logic [2:0] SEL_CFG   = 3'd2;
  localparam logic [2:0] SEL_CTL   = 3'd3;
  localparam logic [2:0] SEL_SETUP = 3'd4;

  typedef enum logic [1:0] {PID_OUT = 2'd0, PID_IN = 2'd1, PID_SETUP = 2'd2, PID_RSVD = 2'd3} tok_pid_e;
  typedef enum logic [1:0] {HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3} hs_e;
  typedef enum logic [1:0] {DIR_OFF = 2'd0, DIR_OUT = 2'd1, DIR_IN = 2'd2, DIR_UNDEF = 2'd3} ep_dir_e;
  typedef enum logic [2:0] {
    ST_IN_ACK = 3'd0, ST_IN_NAK = 3'd1, ST_OUT0 = 3'd2, ST_SETUP = 3'd3,
    ST_OUT1 = 3'd6, ST_ISO = 3'd7
  } sts_e;

  typedef struct packed {
    logic [NUM_W-1:0] num;
    ep_dir_e          dir;
    logic             iso;
    logic             tog;
    logic             cstall;
    logic             stall;
    logic             ready;
    logic [SEG_W-1:0] seg;
    logic [LEN_W-1:0] len;
  } ep_state_t;

  typedef struct packed {
    hs_e               hs;
    logic              data1;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] addr;
    logic              sts_vld;
    sts_e              code;
    logic              ovr;
    logic              flip;
    logic              disarm;
    logic              len_we;
    logic [LEN_W-1:0]  new_len;
  } decision_t;
endpackage

// File: rtl/usb_ep_slot.sv
module usb_ep_slot
  import usb_ep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_seg_i,
  input  logic             wr_len_i,
  input  logic             wr_cfg_i,
  input  logic             wr_ctl_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             upd_i,
  input  logic             upd_flip_i,
  input  logic             upd_disarm_i,
  input  logic             upd_len_we_i,
  input  logic [LEN_W-1:0] upd_len_i,
  output ep_state_t        state_o
);
  ep_state_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      if (wr_seg_i) st_q.seg <= wdata_i[3 +: SEG_W];
      if (wr_cfg_i) begin
        st_q.dir    <= ep_dir_e'(wdata_i[1:0]);
        st_q.iso    <= wdata_i[2];
        st_q.tog    <= wdata_i[3];
        st_q.cstall <= wdata_i[4];
        st_q.num    <= wdata_i[8 +: NUM_W];
      end else if (upd_i && upd_flip_i) begin
        st_q.tog <= ~st_q.tog;
      end
      if (upd_i && upd_len_we_i) st_q.len <= upd_len_i;
      if (upd_i && upd_disarm_i) st_q.ready <= 1'b0;
      if (wr_ctl_i) begin
        st_q.stall <= wdata_i[1];
        if (wdata_i[0]) st_q.ready <= 1'b0;
      end
      // software arming wins over a same-cycle completion
      if (wr_len_i) begin
        st_q.len   <= wdata_i[LEN_W-1:0];
        st_q.ready <= 1'b1;
      end
    end
  end

  assign state_o = st_q;

  assert_arm_sets_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_len_i |=> st_q.ready);
  assert_disarm_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl_i && wdata_i[0] && !wr_len_i) |=> !st_q.ready);
  assert_toggle_flips_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_flip_i && !wr_cfg_i) |=> (st_q.tog != $past(st_q.tog)));
endmodule

// File: rtl/usb_ep_decide.sv
module usb_ep_decide
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned IDX_W = $clog2(NUM_EP)
) (
  input  tok_pid_e          tok_pid_i,
  input  logic [NUM_W-1:0]  tok_ep_i,
  input  logic [LEN_W:0]    tok_len_i,
  input  logic              tok_data1_i,
  input  ep_state_t         eps_i [NUM_EP],
  input  logic [SEG_W-1:0]  setup_seg_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output decision_t         dec_o
);
  ep_state_t e;
  logic      ovr_out;

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    // descending scan: lowest matching slot wins
    for (int k = NUM_EP - 1; k >= 0; k--) begin
      if (eps_i[k].num == tok_ep_i &&
          ((tok_pid_i == PID_IN    && eps_i[k].dir == DIR_IN) ||
           (tok_pid_i == PID_OUT   && eps_i[k].dir == DIR_OUT) ||
           (tok_pid_i == PID_SETUP && (eps_i[k].dir == DIR_IN || eps_i[k].dir == DIR_OUT)))) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(k);
      end
    end
  end

  assign e       = eps_i[hit_idx_o];
  assign ovr_out = tok_len_i > {1'b0, e.len};

  always_comb begin
    dec_o      = '0;
    dec_o.addr = {e.seg, 3'b000};
    unique case (tok_pid_i)
      PID_SETUP: begin
        dec_o.addr = {setup_seg_i, 3'b000};
        if (e.stall && !e.cstall) begin
          dec_o.hs = HS_STALL;
        end else begin
          dec_o.hs      = HS_ACK;
          dec_o.sts_vld = 1'b1;
          dec_o.code    = ST_SETUP;
          dec_o.ovr     = tok_len_i > (LEN_W+1)'(SETUP_MAX);
        end
      end
      PID_IN: begin
        if (e.stall) begin
          dec_o.hs = HS_STALL;
        end else if (e.ready) begin
          dec_o.len     = e.len;
          dec_o.data1   = e.tog;
          dec_o.disarm  = 1'b1;
          dec_o.sts_vld = 1'b1;
          if (e.iso) begin
            dec_o.code = ST_ISO;
          end else begin
            dec_o.hs   = HS_ACK;
            dec_o.code = ST_IN_ACK;
            dec_o.flip = 1'b1;
          end
        end else if (!e.iso) begin
          dec_o.hs      = HS_NAK;
          dec_o.sts_vld = 1'b1;
          dec_o.code    = ST_IN_NAK;
        end
      end
      PID_OUT: begin
        if (e.stall) begin
          dec_o.hs = HS_STALL;
        end else if (e.ready) begin
          dec_o.ovr     = ovr_out;
          dec_o.len_we  = 1'b1;
          dec_o.new_len = ovr_out ? e.len : tok_len_i[LEN_W-1:0];
          dec_o.disarm  = 1'b1;
          dec_o.sts_vld = 1'b1;
          if (e.iso) begin
            dec_o.code = ST_ISO;
          end else begin
            dec_o.hs   = HS_ACK;
            dec_o.code = tok_data1_i ? ST_OUT1 : ST_OUT0;
          end
        end else if (!e.iso) begin
          dec_o.hs = HS_NAK;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_ep_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned IDX_W = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_ep_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [IDX_W-1:0]  reg_rd_ep_i,
  input  logic [2:0]        reg_rd_sel_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_pid_i,
  input  logic [NUM_W-1:0]  tok_ep_i,
  input  logic [LEN_W:0]    tok_len_i,
  input  logic              tok_data1_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_hs_o,
  output logic              resp_data1_o,
  output logic [LEN_W-1:0]  resp_len_o,
  output logic [ADDR_W-1:0] resp_addr_o,
  output logic              sts_valid_o,
  output logic [2:0]        sts_code_o,
  output logic [IDX_W-1:0]  sts_slot_o,
  output logic              overrun_o
);
  ep_state_t        eps [NUM_EP];
  logic [SEG_W-1:0] setup_seg_q;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  decision_t        dec;
  logic             take;

  assign take = tok_valid_i && hit;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
    logic sel_me;
    assign sel_me = reg_we_i && (reg_ep_i == IDX_W'(g));
    usb_ep_slot u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_seg_i     (sel_me && reg_sel_i == SEL_SEG),
      .wr_len_i     (sel_me && reg_sel_i == SEL_LEN),
      .wr_cfg_i     (sel_me && reg_sel_i == SEL_CFG),
      .wr_ctl_i     (sel_me && reg_sel_i == SEL_CTL),
      .wdata_i      (reg_wdata_i),
      .upd_i        (take && hit_idx == IDX_W'(g)),
      .upd_flip_i   (dec.flip),
      .upd_disarm_i (dec.disarm),
      .upd_len_we_i (dec.len_we),
      .upd_len_i    (dec.new_len),
      .state_o      (eps[g])
    );
  end

  usb_ep_decide #(.NUM_EP(NUM_EP)) u_decide (
    .tok_pid_i   (tok_pid_e'(tok_pid_i)),
    .tok_ep_i    (tok_ep_i),
    .tok_len_i   (tok_len_i),
    .tok_data1_i (tok_data1_i),
    .eps_i       (eps),
    .setup_seg_i (setup_seg_q),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .dec_o       (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_seg_q <= '0;
    end else if (reg_we_i && reg_sel_i == SEL_SETUP) begin
      setup_seg_q <= reg_wdata_i[3 +: SEG_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hs_o    <= HS_NONE;
      resp_data1_o <= 1'b0;
      resp_len_o   <= '0;
      resp_addr_o  <= '0;
      sts_valid_o  <= 1'b0;
      sts_code_o   <= '0;
      sts_slot_o   <= '0;
      overrun_o    <= 1'b0;
    end else begin
      resp_valid_o <= tok_valid_i;
      resp_hs_o    <= take ? dec.hs : HS_NONE;
      resp_data1_o <= take && dec.data1;
      resp_len_o   <= take ? dec.len : '0;
      resp_addr_o  <= take ? dec.addr : '0;
      sts_valid_o  <= take && dec.sts_vld;
      sts_code_o   <= take ? dec.code : '0;
      sts_slot_o   <= hit_idx;
      overrun_o    <= take && dec.ovr;
    end
  end

  ep_state_t rd_e;
  assign rd_e = eps[reg_rd_ep_i];

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_rd_sel_i)
      SEL_SEG:   reg_rdata_o = REG_W'({rd_e.seg, 3'b000});
      SEL_LEN:   reg_rdata_o = REG_W'(rd_e.len);
      SEL_CFG:   reg_rdata_o = {rd_e.num, 3'b000, rd_e.cstall, rd_e.tog, rd_e.iso, rd_e.dir};
      SEL_CTL:   reg_rdata_o = REG_W'({rd_e.stall, 1'b0});
      SEL_SETUP: reg_rdata_o = REG_W'({setup_seg_q, 3'b000});
      default:   ;
    endcase
  end

  assert_stall_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hs_o == HS_STALL) |-> !sts_valid_o);
  assert_overrun_with_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> sts_valid_o);
  assert_code_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_valid_o |-> (sts_code_o != 3'd4 && sts_code_o != 3'd5));
  assert_iso_no_handshake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_valid_o && sts_code_o == ST_ISO) |-> resp_hs_o == HS_NONE);
  assert_status_needs_token_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !sts_valid_o);
  assert_clear_bit_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_sel_i == SEL_CTL) |-> !reg_rdata_o[0]);
endmodule

// File: tb/usb_ep_handshake_tb_top.sv
module usb_ep_handshake_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_ep = '0, reg_sel = '0, rd_ep = '0, rd_sel = '0;
  logic [11:0] wdata = '0, rdata;
  logic        tok_valid = 1'b0, tok_data1 = 1'b0;
  logic [1:0]  tok_pid = '0;
  logic [3:0]  tok_ep = '0;
  logic [9:0]  tok_len = '0;
  logic        resp_valid, resp_data1, sts_valid, overrun;
  logic [1:0]  resp_hs;
  logic [8:0]  resp_len, resp_addr;
  logic [2:0]  sts_code, sts_slot;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_tog = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_handshake dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_ep_i(reg_ep), .reg_sel_i(reg_sel), .reg_wdata_i(wdata),
    .reg_rd_ep_i(rd_ep), .reg_rd_sel_i(rd_sel), .reg_rdata_o(rdata),
    .tok_valid_i(tok_valid), .tok_pid_i(tok_pid), .tok_ep_i(tok_ep),
    .tok_len_i(tok_len), .tok_data1_i(tok_data1),
    .resp_valid_o(resp_valid), .resp_hs_o(resp_hs), .resp_data1_o(resp_data1),
    .resp_len_o(resp_len), .resp_addr_o(resp_addr),
    .sts_valid_o(sts_valid), .sts_code_o(sts_code), .sts_slot_o(sts_slot),
    .overrun_o(overrun)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int ep, int sel, int data);
    @(negedge clk);
    reg_we = 1'b1; reg_ep = 3'(ep); reg_sel = 3'(sel); wdata = 12'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int ep, int sel, output int val);
    rd_ep = 3'(ep); rd_sel = 3'(sel);
    #1 val = int'(rdata);
  endtask

  // token driven at a falling edge, response sampled at the next falling edge
  task automatic tok(int pid, int ep, int len, bit d1);
    @(negedge clk);
    tok_valid = 1'b1; tok_pid = 2'(pid); tok_ep = 4'(ep); tok_len = 10'(len); tok_data1 = d1;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  function automatic int cfg(int dir, int iso, int tog, int cst, int num);
    return dir | (iso << 2) | (tog << 3) | (cst << 4) | (num << 8);
  endfunction

  task automatic t_reset();
    int v;
    check("R12 resp_valid", resp_valid, 0);
    check("R12 sts_valid", sts_valid, 0);
    rd(1, 2, v); check("R12 cfg readback", v, 0);
    rd(1, 1, v); check("R12 len readback", v, 0);
  endtask

  task automatic t_setup_slots();
    int v;
    wr(1, 0, 12'h02D);                       // low bits dropped
    rd(1, 0, v); check("R1 seg readback", v, 'h28);
    wr(1, 2, cfg(2, 0, 0, 0, 2));
    wr(3, 0, 'h40); wr(3, 2, cfg(1, 0, 0, 0, 2));
    wr(4, 2, cfg(2, 0, 0, 0, 2));
    wr(5, 2, cfg(3, 0, 0, 0, 7));
    wr(6, 2, cfg(1, 1, 0, 0, 9));
    wr(0, 2, cfg(0, 0, 0, 0, 0));
  endtask

  task automatic t_in_nak();
    tok(1, 2, 0, 0);
    check("R6 IN nak hs", resp_hs, 2);
    check("R6 IN nak sts", sts_valid, 1);
    check("R6 IN nak code", sts_code, 1);
    check("R4 slot", sts_slot, 1);
    check("R5 nak keeps toggle", resp_data1, 0);
  endtask

  task automatic t_in_ack();
    wr(1, 1, 20);
    tok(1, 2, 0, 0);
    check("R2 IN hs", resp_hs, 1);
    check("R2 IN len", resp_len, 20);
    check("R1 IN addr", resp_addr, 'h28);
    check("R5 first pid", resp_data1, exp_tog);
    check("R2 IN code", sts_code, 0);
    exp_tog = ~exp_tog;
    tok(1, 2, 0, 0);
    check("R2 disarmed after IN", resp_hs, 2);
    wr(1, 1, 5);
    tok(1, 2, 0, 0);
    check("R5 toggled pid", resp_data1, exp_tog);
    check("R2 second len", resp_len, 5);
    exp_tog = ~exp_tog;
  endtask

  task automatic t_disarm();
    int v;
    wr(1, 1, 12);
    wr(1, 3, 1);
    rd(1, 3, v); check("R3 clear bit reads 0", v, 0);
    tok(1, 2, 0, 0);
    check("R3 disarmed gives NAK", resp_hs, 2);
  endtask

  task automatic t_out();
    int v;
    wr(3, 1, 16);
    tok(0, 2, 10, 1);
    check("R8 OUT hs", resp_hs, 1);
    check("R8 OUT code data1", sts_code, 6);
    check("R1 OUT addr", resp_addr, 'h40);
    check("R4 OUT slot", sts_slot, 3);
    rd(3, 1, v); check("R8 received len", v, 10);
    tok(0, 2, 4, 0);
    check("R6 OUT nak hs", resp_hs, 2);
    check("R6 OUT nak no sts", sts_valid, 0);
    wr(3, 1, 16);
    tok(0, 2, 0, 0);
    check("R8 OUT code data0", sts_code, 2);
    check("R9 no overrun", overrun, 0);
  endtask

  task automatic t_overrun();
    int v;
    wr(3, 1, 8);
    tok(0, 2, 9, 0);
    check("R9 OUT overrun", overrun, 1);
    check("R9 OUT still ack", resp_hs, 1);
    rd(3, 1, v); check("R9 stored limit", v, 8);
  endtask

  task automatic t_routing();
    tok(1, 5, 0, 0);
    check("R4 unmatched hs", resp_hs, 0);
    check("R4 unmatched valid", resp_valid, 1);
    check("R4 unmatched sts", sts_valid, 0);
    tok(1, 0, 0, 0);
    check("R4 disabled slot", resp_hs, 0);
    tok(1, 7, 0, 0);
    check("R4 undefined slot", resp_hs, 0);
    tok(3, 2, 0, 0);
    check("R12 reserved pid", resp_hs, 0);
  endtask

  task automatic t_stall();
    wr(1, 1, 30);
    wr(1, 3, 2);
    tok(1, 2, 0, 0);
    check("R7 IN stall hs", resp_hs, 3);
    check("R7 stall no sts", sts_valid, 0);
    tok(2, 2, 8, 0);
    check("R7 setup stalled", resp_hs, 3);
    wr(1, 2, cfg(2, 0, exp_tog, 1, 2));
    tok(2, 2, 8, 0);
    check("R7 setup override ack", resp_hs, 1);
    wr(1, 3, 0);
    tok(1, 2, 0, 0);
    check("R7 armed kept", resp_hs, 1);
    check("R7 len kept", resp_len, 30);
    check("R5 pid after stall", resp_data1, exp_tog);
    exp_tog = ~exp_tog;
  endtask

  task automatic t_setup();
    wr(0, 4, 'h80);
    tok(2, 2, 8, 0);
    check("R11 setup hs", resp_hs, 1);
    check("R11 setup code", sts_code, 3);
    check("R11 setup addr", resp_addr, 'h80);
    check("R9 setup 8 ok", overrun, 0);
    tok(2, 2, 9, 0);
    check("R9 setup overrun", overrun, 1);
  endtask

  task automatic t_iso();
    wr(6, 1, 32);
    tok(0, 9, 32, 0);
    check("R10 iso hs", resp_hs, 0);
    check("R10 iso sts", sts_valid, 1);
    check("R10 iso code", sts_code, 7);
    tok(0, 9, 32, 0);
    check("R10 unarmed iso hs", resp_hs, 0);
    check("R10 unarmed iso sts", sts_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_setup_slots();
    t_in_nak();
    t_in_ack();
    t_disarm();
    t_out();
    t_overrun();
    t_routing();
    t_stall();
    t_setup();
    t_iso();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule